// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit sits beside a data cache's store path and turns one atomic instruction into the value that goes back to memory. In a single cycle it combines the value just read from memory with the register operand under a 5-bit operation code, and says whether that value should be written at all. Operands can be 64 bits wide (doubleword) or 32 bits wide (word). A word operation sign-extends both operands from their low halves, and its result is copied into both 32-bit halves of the write data.

The unit also holds one load-reserved / store-conditional reservation. A load-reserved records the operand width and the address. A later store-conditional succeeds only if that reservation is still valid and matches on both width and address. The unit does no cache lookup, memory access, alignment check or exception handling.

Top module: `amo_unit`

## Requirements
- R1: With opcode bit 4 clear (doubleword), the low four opcode bits select the result: 0000 sum, 0010 bitwise xor, 0110 bitwise and, 0100 bitwise or, 0011 the register operand (swap). `store_en` is 1 for each of these.
- R2: Code 1100 gives the unsigned minimum of the two operands, 1110 the unsigned maximum, 1000 the signed minimum and 1010 the signed maximum.
- R3: With opcode bit 4 set (word), both operands are sign-extended from bit 31 before the operation. The low 32 bits of the result then appear in both `result[31:0]` and `result[63:32]`.
- R4: Load-reserved (low code `LR_CODE`, default 0001) returns the loaded value with `store_en` 0. While `req_valid` is high it records a reservation holding the width bit and `req_addr`.
- R5: Store-conditional (low code `SC_CODE`, default 0101) returns the register operand. When a valid reservation matches both the width bit and the address, it reports `sc_valid` 1 and `sc_status` 0, sets `store_en` to 1, and clears the reservation.
- R6: A store-conditional with no reservation, a different address or a different width bit reports `sc_status` 1 with `store_en` 0. A failure leaves the reservation unchanged.
- R7: Any other low opcode code returns the loaded value (sign-extended and copied to both halves in word mode) with `store_en` 1.
- R8: A synchronous reset (`rst` high at a clock edge) leaves the reservation invalid.
- R9: With `req_valid` low, `store_en` and `sc_valid` are 0 and the reservation does not change.
- R10: `result`, `store_en`, `sc_valid` and `sc_status` depend on the current inputs and the reservation in the same cycle. A reservation change made by a request takes effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe for this cycle |
| op_code | input | 5 | Bit 4 selects word width; bits 3:0 select the operation |
| loaded_val | input | DATA_W | Value read from memory |
| reg_operand | input | DATA_W | Register source operand |
| req_addr | input | ADDR_W | Physical address of the access |
| result | output | DATA_W | Value to write back |
| store_en | output | 1 | Write `result` to memory |
| sc_valid | output | 1 | A store-conditional status is present |
| sc_status | output | 1 | 0 means success, 1 means failure |

## Verification
Every output comes from combinational logic, so its value for a request is due in the cycle that request is applied. The bench drives inputs just after a falling edge and samples one nanosecond later, before the next rising edge. A reservation change is registered, so its effect is checked on a later request. That request is driven only after the rising edge that commits the earlier one. The tests for reset and for an idle strobe check the reservation through a store-conditional that follows.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [3:0] {
    AOP_ADD  = 4'b0000,
    AOP_XOR  = 4'b0010,
    AOP_SWAP = 4'b0011,
    AOP_OR   = 4'b0100,
    AOP_AND  = 4'b0110,
    AOP_SMIN = 4'b1000,
    AOP_SMAX = 4'b1010,
    AOP_UMIN = 4'b1100,
    AOP_UMAX = 4'b1110
  } amo_op_e;

  typedef struct packed {
    logic is_word;
    logic is_lr;
    logic is_sc;
  } amo_dec_t;
endpackage

// File: rtl/amo_alu.sv
module amo_alu #(
  parameter int DATA_W = 64
) (
  input  logic              word_mode,
  input  logic [3:0]        code,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] src_val,
  output logic [DATA_W-1:0] op_mem,
  output logic [DATA_W-1:0] op_src,
  output logic [DATA_W-1:0] alu_out
);
  import amo_pkg::*;
  localparam int HW = DATA_W / 2;

  function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] v, input logic w);
    return w ? {{HW{v[HW-1]}}, v[HW-1:0]} : v;
  endfunction

  function automatic logic [DATA_W-1:0] pick(input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b,
                                             input logic sgn, input logic want_max);
    logic a_lt;
    a_lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
    return (a_lt ^ want_max) ? a : b;
  endfunction

  assign op_mem = widen(mem_val, word_mode);
  assign op_src = widen(src_val, word_mode);

  always_comb begin
    case (code)
      AOP_ADD:  alu_out = op_mem + op_src;
      AOP_XOR:  alu_out = op_mem ^ op_src;
      AOP_AND:  alu_out = op_mem & op_src;
      AOP_OR:   alu_out = op_mem | op_src;
      AOP_SWAP: alu_out = op_src;
      AOP_UMIN: alu_out = pick(op_mem, op_src, 1'b0, 1'b0);
      AOP_UMAX: alu_out = pick(op_mem, op_src, 1'b0, 1'b1);
      AOP_SMIN: alu_out = pick(op_mem, op_src, 1'b1, 1'b0);
      AOP_SMAX: alu_out = pick(op_mem, op_src, 1'b1, 1'b1);
      default:  alu_out = op_mem;
    endcase
  end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic              new_word,
  input  logic [ADDR_W-1:0] new_addr,
  input  logic              cmp_word,
  input  logic [ADDR_W-1:0] cmp_addr,
  output logic              hit,
  output logic              held
);
  logic              word_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held   <= 1'b0;
      word_q <= 1'b0;
      addr_q <= '0;
    end else if (set_en) begin
      held   <= 1'b1;
      word_q <= new_word;
      addr_q <= new_addr;
    end else if (clr_en) begin
      held <= 1'b0;
    end
  end

  assign hit = held && (word_q == cmp_word) && (addr_q == cmp_addr);
endmodule

// File: rtl/amo_unit.sv
module amo_unit #(
  parameter int         DATA_W  = 64,
  parameter int         ADDR_W  = 40,
  parameter logic [3:0] LR_CODE = 4'b0001,
  parameter logic [3:0] SC_CODE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [4:0]        op_code,
  input  logic [DATA_W-1:0] loaded_val,
  input  logic [DATA_W-1:0] reg_operand,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] result,
  output logic              store_en,
  output logic              sc_valid,
  output logic              sc_status
);
  import amo_pkg::*;
  localparam int HW = DATA_W / 2;

  amo_dec_t          dec;
  logic [DATA_W-1:0] op_mem_w, op_src_w, alu_w, pre_rep;
  logic              resv_hit_w, resv_valid_w;
  logic              lr_fire_w, sc_ok_w;

  assign dec.is_word = op_code[4];
  assign dec.is_lr   = (op_code[3:0] == LR_CODE);
  assign dec.is_sc   = (op_code[3:0] == SC_CODE);

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .word_mode(dec.is_word), .code(op_code[3:0]),
    .mem_val(loaded_val), .src_val(reg_operand),
    .op_mem(op_mem_w), .op_src(op_src_w), .alu_out(alu_w)
  );

  assign lr_fire_w = req_valid && dec.is_lr;
  assign sc_ok_w   = req_valid && dec.is_sc && resv_hit_w;

  amo_resv #(.ADDR_W(ADDR_W)) u_resv (
    .clk(clk), .rst(rst),
    .set_en(lr_fire_w), .clr_en(sc_ok_w),
    .new_word(dec.is_word), .new_addr(req_addr),
    .cmp_word(dec.is_word), .cmp_addr(req_addr),
    .hit(resv_hit_w), .held(resv_valid_w)
  );

  always_comb begin
    if (dec.is_lr)      pre_rep = op_mem_w;
    else if (dec.is_sc) pre_rep = op_src_w;
    else                pre_rep = alu_w;
  end

  assign result    = dec.is_word ? {2{pre_rep[HW-1:0]}} : pre_rep;
  assign sc_valid  = req_valid && dec.is_sc;
  assign sc_status = !resv_hit_w;
  assign store_en  = req_valid && !dec.is_lr && (!dec.is_sc || resv_hit_w);
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int         DATA_W  = 64,
  parameter logic [3:0] LR_CODE = 4'b0001
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [4:0]        op_code,
  input logic [DATA_W-1:0] result,
  input logic              store_en,
  input logic              sc_valid,
  input logic              sc_status,
  input logic              resv_valid
);
  localparam int HW = DATA_W / 2;

  AST_LR_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op_code[3:0] == LR_CODE) |-> !store_en); // R4
  AST_LR_RESERVES: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op_code[3:0] == LR_CODE) |=> resv_valid); // R4
  AST_SC_OK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && !sc_status) |=> !resv_valid); // R5
  AST_SC_FAIL_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && sc_status) |-> !store_en); // R6
  AST_WORD_REPLICA: assert property (@(posedge clk) disable iff (rst)
    op_code[4] |-> (result[DATA_W-1:HW] == result[HW-1:0])); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !resv_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!store_en && !sc_valid)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(resv_valid)); // R9
endmodule

bind amo_unit amo_unit_chk #(.DATA_W(DATA_W), .LR_CODE(LR_CODE)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .op_code(op_code),
  .result(result), .store_en(store_en), .sc_valid(sc_valid),
  .sc_status(sc_status), .resv_valid(resv_valid_w)
);

// File: tb/tb_amo_unit.sv
module tb_amo_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [4:0]  op_code;
  logic [63:0] loaded_val, reg_operand;
  logic [39:0] req_addr;
  logic [63:0] result;
  logic        store_en, sc_valid, sc_status;
  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [3:0] LR = 4'b0001;
  localparam logic [3:0] SC = 4'b0101;

  always #2 clk = ~clk;

  amo_unit dut (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic w, input logic [3:0] c,
                                        input logic [63:0] m, input logic [63:0] s);
    logic signed [63:0] a, b;
    logic [63:0] r;
    a = w ? 64'($signed(m[31:0])) : m;
    b = w ? 64'($signed(s[31:0])) : s;
    unique case (c)
      4'b0000: r = a + b;
      4'b0010: r = a ^ b;
      4'b0110: r = a & b;
      4'b0100: r = a | b;
      4'b0011: r = b;
      4'b1100: r = ($unsigned(a) > $unsigned(b)) ? b : a;
      4'b1110: r = ($unsigned(a) > $unsigned(b)) ? a : b;
      4'b1000: r = (a > b) ? b : a;
      4'b1010: r = (a > b) ? a : b;
      default: r = a;
    endcase
    return w ? {r[31:0], r[31:0]} : r;
  endfunction

  // drive after negedge, sample 1 ns later, commit at next posedge
  task automatic apply(input logic v, input logic [4:0] op, input logic [63:0] m,
                       input logic [63:0] s, input logic [39:0] ad);
    @(negedge clk);
    req_valid = v; op_code = op; loaded_val = m; reg_operand = s; req_addr = ad;
    #1;
  endtask

  task automatic t_reset;
    apply(1'b1, {1'b0, SC}, 64'h0, 64'h55, 40'h100);
    chk("R8 sc after reset status", 64'(sc_status), 64'd1);
    chk("R6 sc fail no store", 64'(store_en), 64'd0);
  endtask

  task automatic t_dword_ops;
    logic [3:0] codes [5] = '{4'b0000, 4'b0010, 4'b0110, 4'b0100, 4'b0011};
    for (int i = 0; i < 5; i++) begin
      apply(1'b1, {1'b0, codes[i]}, 64'hF0F0_1234_0000_FFFF, 64'h0FF0_0001_FFFF_0001, 40'h8);
      chk($sformatf("R1 code %b", codes[i]), result,
          model(1'b0, codes[i], 64'hF0F0_1234_0000_FFFF, 64'h0FF0_0001_FFFF_0001));
      chk("R1 store_en", 64'(store_en), 64'd1);
    end
  endtask

  task automatic t_minmax;
    logic [3:0] codes [4] = '{4'b1100, 4'b1110, 4'b1000, 4'b1010};
    logic [63:0] exp [4] = '{64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1};
    for (int i = 0; i < 4; i++) begin
      apply(1'b1, {1'b0, codes[i]}, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 40'h10);
      chk($sformatf("R2 code %b", codes[i]), result, exp[i]);
    end
  endtask

  task automatic t_word;
    apply(1'b1, 5'b10000, 64'h1234_5678_8000_0000, 64'hAAAA_BBBB_8000_0001, 40'h20);
    chk("R3 word add", result, 64'h0000_0001_0000_0001);
    apply(1'b1, 5'b11000, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 40'h20);
    chk("R3 word smin", result, 64'h8000_0000_8000_0000);
    apply(1'b1, 5'b11100, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 40'h20);
    chk("R3 word umin", result, 64'h7FFF_FFFF_7FFF_FFFF);
  endtask

  task automatic t_lr_sc;
    apply(1'b1, {1'b0, LR}, 64'hDEAD_BEEF_0BAD_F00D, 64'h1, 40'h400);
    chk("R4 lr value", result, 64'hDEAD_BEEF_0BAD_F00D);
    chk("R4 lr no store", 64'(store_en), 64'd0);
    apply(1'b1, {1'b0, SC}, 64'h0, 64'h1111_2222_3333_4444, 40'h400);
    chk("R5 sc ok status", 64'(sc_status), 64'd0);
    chk("R5 sc ok valid", 64'(sc_valid), 64'd1);
    chk("R5 sc store_en", 64'(store_en), 64'd1);
    chk("R5 sc result", result, 64'h1111_2222_3333_4444);
    apply(1'b1, {1'b0, SC}, 64'h0, 64'h1, 40'h400);
    chk("R5 second sc fails", 64'(sc_status), 64'd1);
  endtask

  task automatic t_sc_mismatch;
    apply(1'b1, {1'b1, LR}, 64'h0000_0000_8000_0001, 64'h0, 40'h500);
    chk("R4 word lr value", result, 64'h8000_0001_8000_0001);
    apply(1'b1, {1'b1, SC}, 64'h0, 64'h7, 40'h508);
    chk("R6 addr mismatch", 64'(sc_status), 64'd1);
    chk("R6 addr mismatch store", 64'(store_en), 64'd0);
    apply(1'b1, {1'b0, SC}, 64'h0, 64'h7, 40'h500);
    chk("R6 width mismatch", 64'(sc_status), 64'd1);
    apply(1'b1, {1'b1, SC}, 64'h0, 64'h0000_0000_0000_0007, 40'h500);
    chk("R6 reservation kept after fail", 64'(sc_status), 64'd0);
    chk("R10 sc word result", result, 64'h0000_0007_0000_0007);
  endtask

  task automatic t_unknown;
    apply(1'b1, 5'b00111, 64'h0123_4567_89AB_CDEF, 64'h5, 40'h0);
    chk("R7 unknown dword", result, 64'h0123_4567_89AB_CDEF);
    chk("R7 unknown store", 64'(store_en), 64'd1);
    apply(1'b1, 5'b11111, 64'h0123_4567_89AB_CDEF, 64'h5, 40'h0);
    chk("R7 unknown word", result, 64'h89AB_CDEF_89AB_CDEF);
  endtask

  task automatic t_idle;
    apply(1'b0, {1'b0, LR}, 64'h9, 64'h0, 40'h600);
    chk("R9 idle store_en", 64'(store_en), 64'd0);
    chk("R9 idle sc_valid", 64'(sc_valid), 64'd0);
    apply(1'b1, {1'b0, SC}, 64'h0, 64'h3, 40'h600);
    chk("R9 idle lr did not reserve", 64'(sc_status), 64'd1);
  endtask

  task automatic t_reset_mid;
    apply(1'b1, {1'b0, LR}, 64'h9, 64'h0, 40'h700);
    @(negedge clk);
    req_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    apply(1'b1, {1'b0, SC}, 64'h0, 64'h3, 40'h700);
    chk("R8 reset drops reservation", 64'(sc_status), 64'd1);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; op_code = '0;
    loaded_val = '0; reg_operand = '0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_dword_ops();
    t_minmax();
    t_word();
    t_lr_sc();
    t_sc_mismatch();
    t_unknown();
    t_idle();
    t_reset_mid();
    @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #40000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule